// File: doc/BRIEF.md
# Debug-Link Instruction Stream Decoder

This block sits behind a serial frame receiver on a two-wire debug link. It takes validated received bytes, plus a pulse for each break condition on the line, and follows the instruction structure of the link. The first byte of each instruction is an opcode. From that byte alone the decoder works out how many operand and data items follow, how wide each item is, and whether the programmer or the device sends it.

It gathers each multi-byte item, least significant byte first, into one value on a 32-bit bus. Each value is tagged with its direction. The decoder strobes once when an instruction finishes, and again when a break cuts an instruction short.

A repeat prefix loads a pending count. The next pointer-based load or store uses that count to move extra data items. Every other instruction leaves the pending count alone. A consumer downstream, such as a trace formatter or a bus-execution stage, uses the opcode strobe and fields, the value strobe and the done strobe. It never has to track byte positions itself.

Top module: `dbg_insn_decoder`

## Requirements
- R1: One cycle after an accepted byte that arrives while the decoder is idle, `op_stb` pulses and `op_code` equals byte bits 7:5. The opcode encoding is:
  - 0: direct load
  - 1: pointer load
  - 2: direct store
  - 3: pointer store
  - 4: control-register load
  - 5: repeat
  - 6: control-register store
  - 7: key
- R2: Direct load and direct store both report `op_addr_w` = bits 3:2 + 1 and `op_data_w` = bits 1:0 + 1. Each first moves an address item of `op_addr_w` bytes, sent by the programmer. The direct load then returns one data item of `op_data_w` bytes from the device. The direct store instead takes one data item of `op_data_w` bytes from the programmer.
- R3: Pointer load and pointer store report `op_ptr` = bits 3:2 and `op_data_w` = bits 1:0 + 1. The pointer store moves data items from the programmer. The pointer load moves them from the device.
- R4: Control-register load and control-register store report `op_reg` = bits 3:0 and `op_data_w` = 1. Each moves exactly one byte. The load moves it from the device and the store from the programmer.
- R5: Each item's value appears on `val_data`, one cycle after its last byte. The first byte received fills bits 7:0, and bits above the item's width read as zero. `val_from_dev` is 1 for items sent by the device and 0 for items sent by the programmer.
- R6: A key instruction is followed by exactly 8 single-byte items, all sent by the programmer.
- R7: A repeat instruction with value N makes the next pointer load or pointer store move N+1 data items. That instruction uses up the count, so a later pointer instruction moves one item.
- R8: Direct load, direct store, both control-register instructions and key leave a pending repeat count unchanged.
- R9: When `in_brk` is high, the instruction in progress is dropped, the pending repeat count is cleared and the next accepted byte is treated as an opcode. Any byte presented in the same cycle is ignored. One cycle later `done_stb` and `done_brk` are both 1.
- R10: `done_stb` pulses with `done_brk` = 0 in the same cycle as the `val_stb` of an instruction's last item, and in no other cycle except after a break.
- R11: After reset, all strobes and output fields are zero and the decoder waits for an opcode.
- R12: A repeat instruction carries one item of bits 1:0 + 1 bytes, sent by the programmer, whose value becomes the pending count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A received byte is present |
| in_byte | input | 8 | Received byte |
| in_brk | input | 1 | Break condition seen on the line |
| op_stb | output | 1 | Opcode decoded this cycle |
| op_code | output | 3 | Opcode, byte bits 7:5 |
| op_addr_w | output | 3 | Address width in bytes for direct access (0 otherwise) |
| op_data_w | output | 3 | Data item width in bytes |
| op_ptr | output | 2 | Pointer mode for pointer access (0 otherwise) |
| op_reg | output | 4 | Control register number (0 otherwise) |
| val_stb | output | 1 | An item has been assembled |
| val_data | output | DATA_W | Assembled item value |
| val_from_dev | output | 1 | 1 for an item sent by the device, 0 for one sent by the programmer |
| done_stb | output | 1 | Instruction finished or aborted |
| done_brk | output | 1 | The finish was caused by a break |

## Verification
All 256 opcode byte values are decoded in turn, each followed by a full set of operand bytes. This separates the field extraction of the eight opcodes from one another and checks each derived item count, width and direction. Repeat values are sent in widths from one to four bytes, and pointer instructions follow them, so the N+1 item count shows up directly in the number of value strobes. Instructions of other types placed between a repeat and the pointer instruction show whether the pending count survives them. Breaks are sent in the middle of an instruction, while idle, and together with a byte in the same cycle, to show the abort, the clearing of the count and the ignored byte.

// File: rtl/dbg_insn_pkg.sv
// Shared opcode encoding and transfer-plan type for the instruction decoder.
// Assumes an opcode byte carries the operation in bits 7:5.
package dbg_insn_pkg;

    typedef enum logic [2:0] {
        OP_LOAD_DIRECT  = 3'd0,
        OP_LOAD_PTR     = 3'd1,
        OP_STORE_DIRECT = 3'd2,
        OP_STORE_PTR    = 3'd3,
        OP_LOAD_CSR     = 3'd4,
        OP_REPEAT       = 3'd5,
        OP_STORE_CSR    = 3'd6,
        OP_KEY          = 3'd7
    } dbg_op_e;

    // Number of single-byte items that follow a key opcode.
    localparam int KEY_LEN = 8;

    // Item counts and widths an opcode implies, before any repeat count.
    typedef struct packed {
        logic [3:0] wr_base;   // items sent by the programmer
        logic [3:0] rd_base;   // items sent by the device
        logic [2:0] w_first;   // width of the first programmer item
        logic [2:0] w_rest;    // width of later programmer items
        logic [2:0] r_w;       // width of device items
        logic       rep_wr;    // repeat count extends programmer items
        logic       rep_rd;    // repeat count extends device items
    } xfer_plan_t;

endpackage

// File: rtl/dbg_op_plan.sv
// Combinational opcode decoder: turns one opcode byte into the reported
// fields and a transfer plan.
// Assumes the byte really is an opcode; the top only uses the result then.
module dbg_op_plan
    import dbg_insn_pkg::*;
(
    input  logic [7:0]  op_byte,
    output xfer_plan_t  plan,
    output logic [2:0]  f_code,
    output logic [2:0]  f_addr_w,
    output logic [2:0]  f_data_w,
    output logic [1:0]  f_ptr,
    output logic [3:0]  f_reg
);

    logic [2:0] hi_w;
    logic [2:0] lo_w;

    assign f_code = op_byte[7:5];
    assign hi_w   = {1'b0, op_byte[3:2]} + 3'd1;
    assign lo_w   = {1'b0, op_byte[1:0]} + 3'd1;

    // Select the fields and the item plan for each opcode.
    always_comb begin
        plan     = '0;
        f_addr_w = '0;
        f_data_w = 3'd1;
        f_ptr    = '0;
        f_reg    = '0;
        unique case (dbg_op_e'(op_byte[7:5]))
            OP_LOAD_DIRECT: begin
                f_addr_w      = hi_w;
                f_data_w      = lo_w;
                plan.wr_base  = 4'd1;
                plan.rd_base  = 4'd1;
                plan.w_first  = hi_w;
                plan.w_rest   = hi_w;
                plan.r_w      = lo_w;
            end
            OP_LOAD_PTR: begin
                f_ptr         = op_byte[3:2];
                f_data_w      = lo_w;
                plan.rd_base  = 4'd1;
                plan.rep_rd   = 1'b1;
                plan.w_first  = lo_w;
                plan.w_rest   = lo_w;
                plan.r_w      = lo_w;
            end
            OP_STORE_DIRECT: begin
                f_addr_w      = hi_w;
                f_data_w      = lo_w;
                plan.wr_base  = 4'd2;
                plan.w_first  = hi_w;
                plan.w_rest   = lo_w;
                plan.r_w      = lo_w;
            end
            OP_STORE_PTR: begin
                f_ptr         = op_byte[3:2];
                f_data_w      = lo_w;
                plan.wr_base  = 4'd1;
                plan.rep_wr   = 1'b1;
                plan.w_first  = lo_w;
                plan.w_rest   = lo_w;
                plan.r_w      = lo_w;
            end
            OP_LOAD_CSR: begin
                f_reg         = op_byte[3:0];
                plan.rd_base  = 4'd1;
                plan.w_first  = 3'd1;
                plan.w_rest   = 3'd1;
                plan.r_w      = 3'd1;
            end
            OP_REPEAT: begin
                f_data_w      = lo_w;
                plan.wr_base  = 4'd1;
                plan.w_first  = lo_w;
                plan.w_rest   = lo_w;
                plan.r_w      = lo_w;
            end
            OP_STORE_CSR: begin
                f_reg         = op_byte[3:0];
                plan.wr_base  = 4'd1;
                plan.w_first  = 3'd1;
                plan.w_rest   = 3'd1;
                plan.r_w      = 3'd1;
            end
            default: begin
                plan.wr_base  = 4'(KEY_LEN);
                plan.w_first  = 3'd1;
                plan.w_rest   = 3'd1;
                plan.r_w      = 3'd1;
            end
        endcase
    end

endmodule

// File: rtl/dbg_val_asm.sv
// Little-endian item assembler: gathers bytes into one value, lowest byte
// first, and flags the byte that completes an item of `width` bytes.
// Assumes 1 <= width <= VAL_BYTES and VAL_BYTES <= 8.
module dbg_val_asm #(
    parameter int VAL_BYTES = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   flush,
    input  logic                   byte_en,
    input  logic [7:0]             byte_in,
    input  logic [2:0]             width,
    output logic                   item_done,
    output logic [VAL_BYTES*8-1:0] item_val
);

    localparam int VW = VAL_BYTES * 8;

    logic [2:0]    idx;
    logic [VW-1:0] acc;

    // Merge the incoming byte at its position and detect the final byte.
    always_comb begin
        item_done = byte_en && (idx == width - 3'd1);
        item_val  = acc | (VW'(byte_in) << {idx, 3'b000});
    end

    // Advance the byte position; restart after a full item or a flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            idx <= '0;
            acc <= '0;
        end else if (byte_en) begin
            if (item_done) begin
                idx <= '0;
                acc <= '0;
            end else begin
                idx <= idx + 3'd1;
                acc <= item_val;
            end
        end
    end

    a_r5_idx_below_width: assert property (@(posedge clk) disable iff (!rst_n)
        byte_en |-> (idx < width));

endmodule

// File: rtl/dbg_insn_decoder.sv
// Instruction stream decoder for a two-wire debug link. It decodes opcode
// bytes, counts the operand and data items in each direction, applies a
// pending repeat count to pointer accesses, and emits assembled values.
// Assumes bytes reach it already checked for parity and framing, and that
// a break arrives as a one-cycle pulse.
module dbg_insn_decoder
    import dbg_insn_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int REP_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        in_byte,
    input  logic              in_brk,
    output logic              op_stb,
    output logic [2:0]        op_code,
    output logic [2:0]        op_addr_w,
    output logic [2:0]        op_data_w,
    output logic [1:0]        op_ptr,
    output logic [3:0]        op_reg,
    output logic              val_stb,
    output logic [DATA_W-1:0] val_data,
    output logic              val_from_dev,
    output logic              done_stb,
    output logic              done_brk
);

    localparam int CNT_W     = REP_W + 1;
    localparam int VAL_BYTES = DATA_W / 8;

    xfer_plan_t        plan;
    logic [2:0]        f_code;
    logic [2:0]        f_addr_w;
    logic [2:0]        f_data_w;
    logic [1:0]        f_ptr;
    logic [3:0]        f_reg;

    logic              busy;
    logic              is_rep;
    logic [CNT_W-1:0]  wr_left;
    logic [CNT_W-1:0]  rd_left;
    logic [2:0]        cur_w;
    logic [2:0]        w_rest;
    logic [2:0]        r_w;
    logic [REP_W-1:0]  rep_cnt;

    logic              accept;
    logic              item_done;
    logic [DATA_W-1:0] item_val;
    logic [CNT_W-1:0]  wr_init;
    logic [CNT_W-1:0]  rd_init;
    logic [CNT_W-1:0]  wr_next;
    logic              item_last;

    dbg_op_plan u_plan (
        .op_byte  (in_byte),
        .plan     (plan),
        .f_code   (f_code),
        .f_addr_w (f_addr_w),
        .f_data_w (f_data_w),
        .f_ptr    (f_ptr),
        .f_reg    (f_reg)
    );

    dbg_val_asm #(.VAL_BYTES(VAL_BYTES)) u_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (in_brk),
        .byte_en   (accept && busy),
        .byte_in   (in_byte),
        .width     (cur_w),
        .item_done (item_done),
        .item_val  (item_val)
    );

    // Work out item counts for a new opcode and detect the final item.
    always_comb begin
        accept    = in_valid && !in_brk;
        wr_init   = CNT_W'(plan.wr_base) + (plan.rep_wr ? CNT_W'(rep_cnt) : '0);
        rd_init   = CNT_W'(plan.rd_base) + (plan.rep_rd ? CNT_W'(rep_cnt) : '0);
        wr_next   = wr_left - CNT_W'(1);
        item_last = ((wr_left == CNT_W'(1)) && (rd_left == '0)) ||
                    ((wr_left == '0) && (rd_left == CNT_W'(1)));
    end

    // Instruction sequencing, repeat bookkeeping and registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy         <= 1'b0;
            is_rep       <= 1'b0;
            wr_left      <= '0;
            rd_left      <= '0;
            cur_w        <= 3'd1;
            w_rest       <= 3'd1;
            r_w          <= 3'd1;
            rep_cnt      <= '0;
            op_stb       <= 1'b0;
            op_code      <= '0;
            op_addr_w    <= '0;
            op_data_w    <= '0;
            op_ptr       <= '0;
            op_reg       <= '0;
            val_stb      <= 1'b0;
            val_data     <= '0;
            val_from_dev <= 1'b0;
            done_stb     <= 1'b0;
            done_brk     <= 1'b0;
        end else begin
            op_stb   <= 1'b0;
            val_stb  <= 1'b0;
            done_stb <= 1'b0;
            done_brk <= 1'b0;
            if (in_brk) begin
                busy     <= 1'b0;
                wr_left  <= '0;
                rd_left  <= '0;
                rep_cnt  <= '0;
                done_stb <= 1'b1;
                done_brk <= 1'b1;
            end else if (in_valid && !busy) begin
                op_stb    <= 1'b1;
                op_code   <= f_code;
                op_addr_w <= f_addr_w;
                op_data_w <= f_data_w;
                op_ptr    <= f_ptr;
                op_reg    <= f_reg;
                wr_left   <= wr_init;
                rd_left   <= rd_init;
                cur_w     <= (wr_init != '0) ? plan.w_first : plan.r_w;
                w_rest    <= plan.w_rest;
                r_w       <= plan.r_w;
                is_rep    <= (f_code == OP_REPEAT);
                busy      <= 1'b1;
                if (plan.rep_wr || plan.rep_rd) begin
                    rep_cnt <= '0;
                end
            end else if (in_valid && item_done) begin
                val_stb  <= 1'b1;
                val_data <= item_val;
                if (wr_left != '0) begin
                    val_from_dev <= 1'b0;
                    wr_left      <= wr_next;
                    cur_w        <= (wr_next != '0) ? w_rest : r_w;
                end else begin
                    val_from_dev <= 1'b1;
                    rd_left      <= rd_left - CNT_W'(1);
                end
                if (item_last) begin
                    busy     <= 1'b0;
                    done_stb <= 1'b1;
                    if (is_rep) begin
                        rep_cnt <= REP_W'(item_val);
                    end
                end
            end
        end
    end

    a_r9_brk_reports: assert property (@(posedge clk) disable iff (!rst_n)
        in_brk |=> (done_stb && done_brk && !busy));

    a_r9_brk_clears_repeat: assert property (@(posedge clk) disable iff (!rst_n)
        in_brk |=> (rep_cnt == '0));

    a_r10_done_with_last_value: assert property (@(posedge clk) disable iff (!rst_n)
        (done_stb && !done_brk) |-> val_stb);

    a_r7_repeat_consumed: assert property (@(posedge clk) disable iff (!rst_n)
        (op_stb && (op_code == OP_LOAD_PTR || op_code == OP_STORE_PTR)) |-> (rep_cnt == '0));

    a_r1_opcode_then_operand: assert property (@(posedge clk) disable iff (!rst_n)
        op_stb |=> !op_stb);

endmodule

// File: tb/tb_dbg_insn_decoder.sv
// Self-checking bench: full opcode-byte sweep plus directed repeat and
// break scenarios, against an arithmetic model of the item plan.
module tb_dbg_insn_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = '0;
    logic        in_brk = 1'b0;
    logic        op_stb;
    logic [2:0]  op_code;
    logic [2:0]  op_addr_w;
    logic [2:0]  op_data_w;
    logic [1:0]  op_ptr;
    logic [3:0]  op_reg;
    logic        val_stb;
    logic [31:0] val_data;
    logic        val_from_dev;
    logic        done_stb;
    logic        done_brk;

    int n_checks = 0;
    int n_fails  = 0;
    int pend     = 0;

    always #10 clk = ~clk;

    dbg_insn_decoder dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .in_brk(in_brk), .op_stb(op_stb), .op_code(op_code),
        .op_addr_w(op_addr_w), .op_data_w(op_data_w), .op_ptr(op_ptr),
        .op_reg(op_reg), .val_stb(val_stb), .val_data(val_data),
        .val_from_dev(val_from_dev), .done_stb(done_stb), .done_brk(done_brk)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Present one byte for one cycle; outputs are valid on return.
    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Pulse a break, optionally with a byte in the same cycle, then check.
    task automatic do_break(input bit with_byte);
        @(negedge clk);
        in_brk   = 1'b1;
        in_valid = with_byte;
        in_byte  = 8'h60;
        @(negedge clk);
        in_brk   = 1'b0;
        in_valid = 1'b0;
        chk(done_stb == 1'b1 && done_brk == 1'b1, "R9", "break done",
            {done_stb, done_brk}, 2'b11);
        chk(op_stb == 1'b0 && val_stb == 1'b0, "R9", "byte with break ignored",
            {op_stb, val_stb}, 0);
        pend = 0;
    endtask

    function automatic string tag_of(input logic [2:0] c);
        case (c)
            3'd0, 3'd2: return "R2";
            3'd1, 3'd3: return "R3";
            3'd4, 3'd6: return "R4";
            3'd5:       return "R12";
            default:    return "R6";
        endcase
    endfunction

    // Send an instruction with operands and compare every output.
    task automatic run_insn(input logic [7:0] op, input logic [31:0] repval,
                            input string tag);
        int iw[0:15];
        bit idev[0:15];
        int n = 0;
        logic [2:0] c = op[7:5];
        int a = int'(op[3:2]) + 1;
        int d = int'(op[1:0]) + 1;
        int nrep = 0;
        int exp_aw = 0;
        int exp_dw = 1;
        int exp_ptr = 0;
        int exp_reg = 0;
        case (c)
            3'd0: begin iw[0] = a; idev[0] = 0; iw[1] = d; idev[1] = 1; n = 2;
                        exp_aw = a; exp_dw = d; end
            3'd2: begin iw[0] = a; idev[0] = 0; iw[1] = d; idev[1] = 0; n = 2;
                        exp_aw = a; exp_dw = d; end
            3'd1, 3'd3: begin
                nrep = pend; pend = 0;
                n = nrep + 1;
                for (int i = 0; i < n; i++) begin iw[i] = d; idev[i] = (c == 3'd1); end
                exp_dw = d; exp_ptr = int'(op[3:2]);
            end
            3'd4: begin iw[0] = 1; idev[0] = 1; n = 1; exp_reg = int'(op[3:0]); end
            3'd6: begin iw[0] = 1; idev[0] = 0; n = 1; exp_reg = int'(op[3:0]); end
            3'd5: begin iw[0] = d; idev[0] = 0; n = 1; exp_dw = d; end
            default: begin
                n = 8;
                for (int i = 0; i < 8; i++) begin iw[i] = 1; idev[i] = 0; end
            end
        endcase
        send_byte(op);
        chk(op_stb == 1'b1, "R1", "opcode strobe", op_stb, 1);
        chk(op_code == c, "R1", "opcode value", op_code, c);
        chk(op_addr_w == 3'(exp_aw) && op_data_w == 3'(exp_dw), tag, "widths",
            {op_addr_w, op_data_w}, {3'(exp_aw), 3'(exp_dw)});
        chk(op_ptr == 2'(exp_ptr) && op_reg == 4'(exp_reg), tag, "ptr/reg",
            {op_ptr, op_reg}, {2'(exp_ptr), 4'(exp_reg)});
        chk(val_stb == 1'b0 && done_stb == 1'b0, "R10", "no value on opcode",
            {val_stb, done_stb}, 0);
        for (int i = 0; i < n; i++) begin
            logic [31:0] expv = '0;
            for (int k = 0; k < iw[i]; k++) begin
                logic [7:0] b;
                if (c == 3'd5) b = repval[8*k +: 8];
                else           b = 8'(int'(op) * 7 + i * 13 + k * 29 + 5);
                expv = expv | (32'(b) << (8 * k));
                send_byte(b);
                if (k < iw[i] - 1) begin
                    chk(val_stb == 1'b0, tag, "no value mid item", val_stb, 0);
                end else begin
                    chk(val_stb == 1'b1, (nrep > 0) ? "R7" : tag, "value strobe", val_stb, 1);
                    chk(val_data == expv, "R5", "value", val_data, expv);
                    chk(val_from_dev == idev[i], tag, "direction", val_from_dev, idev[i]);
                    chk(done_stb == (i == n - 1) && done_brk == 1'b0, "R10", "done",
                        {done_stb, done_brk}, {(i == n - 1), 1'b0});
                end
            end
            if (c == 3'd5) pend = int'(expv);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk({op_stb, val_stb, done_stb, done_brk} == 0, "R11", "strobes after reset",
            {op_stb, val_stb, done_stb, done_brk}, 0);
        chk({op_code, op_addr_w, op_data_w, op_ptr, op_reg} == 0 && val_data == 0,
            "R11", "fields after reset", val_data, 0);

        // Sweep of every opcode byte; repeat values kept small.
        for (int op = 0; op < 256; op++) begin
            run_insn(8'(op), 32'(op & 3), tag_of(3'(op >> 5)));
        end

        // R8: a pending count survives non-pointer instructions.
        run_insn(8'hA0, 32'd2, "R12");
        run_insn(8'h05, 0, "R8");
        run_insn(8'h41, 0, "R8");
        run_insn(8'h82, 0, "R8");
        run_insn(8'hC2, 0, "R8");
        run_insn(8'hE0, 0, "R8");
        run_insn(8'h61, 0, "R7");   // three items expected
        run_insn(8'h20, 0, "R7");   // count consumed: one item

        // R7: four-byte repeat value, then a pointer load.
        run_insn(8'hA3, 32'd5, "R12");
        run_insn(8'h23, 0, "R7");

        // R9: break in the middle of a direct store.
        send_byte(8'h4F);
        send_byte(8'h11);
        send_byte(8'h22);
        do_break(1'b0);
        run_insn(8'h20, 0, "R9");

        // R9: break clears the repeat count and a simultaneous byte is dropped.
        run_insn(8'hA0, 32'd3, "R12");
        do_break(1'b1);
        run_insn(8'h60, 0, "R9");

        // R9: break while idle.
        do_break(1'b0);
        run_insn(8'h80, 0, "R9");

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule